// File: doc/BRIEF.md
# Two-level cascaded DMA service engine

This block decides which of eight DMA channels is served next and carries out one transfer step for that channel. The eight channels form two groups of four. Channels 0 to 3 move bytes, and channels 4 to 7 move words. Slot 4 of the word group does not belong to any device. It stands for the whole byte group, so any unmasked byte request raises a request in that slot.

Arbitration is fixed priority at both levels, and the lowest channel number wins. The engine raises a hold request to the bus owner when the word group has an unmasked request, including the forwarded one in slot 4. Each clock in which hold acknowledge is high and a winner exists performs one transfer step. One register stage after that clock the engine shows:
- the acknowledge for the channel;
- the 24-bit physical address;
- the transfer direction;
- a memory-cycle strobe.

The step then updates the channel's address and count. When the count wraps, the engine raises a terminal-count pulse. It then either reloads the channel from its base values or masks the channel.

Channel parameters are loaded through a simple load port, and masks are set or cleared one channel at a time. Moving the data itself is left to the surrounding logic.

Top module: `dma_cascade_engine`

## Requirements
- R1: Within each group of four, the lowest-numbered channel whose request line is high and whose mask is clear wins. A request counts only while its line is high, so lowering a line removes that channel from the next arbitration.
- R2: Any unmasked byte request (channels 0 to 3) acts as a request in word slot 4, which has no request line of its own. Slot 4 is gated by its own mask. When a byte channel is served, `dack` carries both that channel's bit and bit 4.
- R3: `hrq` is registered. It is high in the cycle after a clock edge at which the word group (slot 4 included) had an unmasked request, and low otherwise.
- R4: At each clock edge where `hlda` is high and a winner exists, the engine performs exactly one transfer step. Over the next cycle, `dack` shows the served channel as a one-hot bit, with bit 4 added for byte channels.
- R5: `phys_addr` is the channel's 8-bit page in bits 23:16, ORed with the current address. For word channels (4 to 7) the current address is shifted left by one first, so its top bit lands on bit 16.
- R6: After each step the current address goes up by one, or down by one when the decrement flag was loaded. The current count goes down by one.
- R7: A step taken when the current count is 0 is the terminal step. On that step:
  - `tc` is high together with `dack`;
  - the channel's bit in `tc_stat` is set;
  - without autoinit, the channel becomes masked, so it is not served again until it is unmasked.
- R8: With autoinit, the terminal step reloads the current address and the current count from the base values. The next step therefore uses the base address again.
- R9: In the cycle in which `tc` is high, `hrq` is low, even if requests are still pending.
- R10: When `hlda` is high and no unmasked request exists, no step happens: `dack`, `tc` and `mem_cyc` stay 0 and no channel state changes.
- R11: `xfer_dir` holds the type of the last step:
  - 00 verify;
  - 01 device to memory;
  - 10 memory to device;
  - 11 undefined.

  `mem_cyc` is high with `dack` only for types 01 and 10. Verify and undefined steps still acknowledge and count.
- R12: After reset all eight masks are set, and `hrq`, `dack` and `tc_stat` are 0. A mask write sets or clears one channel's mask. A load of a channel's parameters clears that channel's `tc_stat` bit. A load or mask write in the same cycle as a step overrides the step's effect on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| byte_drq | input | 4 | Request lines of channels 0 to 3 |
| word_drq | input | 3 | Request lines of channels 5 to 7 (bit i is channel 4+i) |
| hlda | input | 1 | Hold acknowledge; one step per clock while high |
| cfg_we | input | 1 | Load strobe for one channel's parameters |
| cfg_chan | input | 3 | Channel to load |
| cfg_page | input | 8 | Page value |
| cfg_addr | input | 16 | Base and current address |
| cfg_count | input | 16 | Base and current count |
| cfg_dec | input | 1 | Decrement address when 1 |
| cfg_autoinit | input | 1 | Reload on terminal count when 1 |
| cfg_type | input | 2 | Transfer type (00 verify, 01 dev-to-mem, 10 mem-to-dev, 11 undefined) |
| mask_we | input | 1 | Mask write strobe |
| mask_chan | input | 3 | Channel whose mask is written |
| mask_val | input | 1 | New mask value (1 = masked) |
| hrq | output | 1 | Hold request to the bus owner |
| dack | output | 8 | Per-channel acknowledge, bit 4 is the cascade acknowledge |
| tc | output | 1 | Terminal-count pulse |
| mem_cyc | output | 1 | A memory cycle accompanies this step |
| xfer_dir | output | 2 | Type of the last step |
| phys_addr | output | 24 | Physical address of the last step |
| tc_stat | output | 8 | Sticky terminal-count flags per channel |

## Verification
The assertions assume that a parameter load or mask write does not target the channel being served in the same cycle. They also assume that `hlda` is held low while reset is asserted. The directed part of the stimulus keeps every load and mask write apart from transfer pulses. The mixed random phase issues only mask writes, and the bench model applies the same override order when one of them coincides with a step. The reference model recomputes priority, cascade forwarding, address arithmetic and terminal-count handling from the requirements. Its outputs are compared with the engine's on every clock.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_TO_MEM = 2'b01,
    XF_TO_DEV = 2'b10,
    XF_UNDEF  = 2'b11
  } xfer_e;

  typedef struct packed {
    logic  dec;
    logic  autoinit;
    xfer_e kind;
  } chan_mode_t;

  localparam chan_mode_t MODE_RST = '{dec: 1'b0, autoinit: 1'b0, kind: XF_VERIFY};

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dma_chan_state.sv
module dma_chan_state
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [PW-1:0] ld_page,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_count,
  input  chan_mode_t    ld_mode,
  input  logic          mask_we,
  input  logic          mask_val,
  output logic [AW-1:0] cur_addr,
  output logic [PW-1:0] page,
  output chan_mode_t    mode,
  output logic          masked,
  output logic          at_zero,
  output logic          tc_flag
);

  logic [AW-1:0] base_a_q, base_a_n, cur_a_q, cur_a_n;
  logic [AW-1:0] base_c_q, base_c_n, cur_c_q, cur_c_n;
  logic [PW-1:0] page_q, page_n;
  chan_mode_t    mode_q, mode_n;
  logic          mask_q, mask_n, tcf_q, tcf_n;
  logic          en;

  always_comb begin
    base_a_n = base_a_q;
    cur_a_n  = cur_a_q;
    base_c_n = base_c_q;
    cur_c_n  = cur_c_q;
    page_n   = page_q;
    mode_n   = mode_q;
    mask_n   = mask_q;
    tcf_n    = tcf_q;
    if (step) begin
      cur_a_n = mode_q.dec ? cur_a_q - 1'b1 : cur_a_q + 1'b1;
      cur_c_n = cur_c_q - 1'b1;
      if (cur_c_q == '0) begin
        tcf_n = 1'b1;
        if (mode_q.autoinit) begin
          cur_a_n = base_a_q;
          cur_c_n = base_c_q;
        end else begin
          mask_n = 1'b1;
        end
      end
    end
    if (load) begin
      base_a_n = ld_addr;
      cur_a_n  = ld_addr;
      base_c_n = ld_count;
      cur_c_n  = ld_count;
      page_n   = ld_page;
      mode_n   = ld_mode;
      tcf_n    = 1'b0;
    end
    if (mask_we) mask_n = mask_val;
  end

  assign en = step | load | mask_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      cur_a_q  <= '0;
      base_c_q <= '0;
      cur_c_q  <= '0;
      page_q   <= '0;
      mode_q   <= MODE_RST;
      mask_q   <= 1'b1;
      tcf_q    <= 1'b0;
    end else if (en) begin
      base_a_q <= base_a_n;
      cur_a_q  <= cur_a_n;
      base_c_q <= base_c_n;
      cur_c_q  <= cur_c_n;
      page_q   <= page_n;
      mode_q   <= mode_n;
      mask_q   <= mask_n;
      tcf_q    <= tcf_n;
    end
  end

  assign cur_addr = cur_a_q;
  assign page     = page_q;
  assign mode     = mode_q;
  assign masked   = mask_q;
  assign at_zero  = (cur_c_q == '0);
  assign tc_flag  = tcf_q;

  // R6: a non-terminal step lowers the count by exactly one
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cur_c_q != '0) |=> (cur_c_q == $past(cur_c_q) - 1'b1));

  // R7: terminal step without autoinit leaves the channel masked
  assert_mask_on_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_c_q == '0 && !mode_q.autoinit && !mask_we) |=> mask_q);

  // R8: terminal step with autoinit restores base address and count
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_c_q == '0 && mode_q.autoinit && !load)
      |=> (cur_a_q == $past(base_a_q) && cur_c_q == $past(base_c_q)));

endmodule

// File: rtl/dma_cascade_engine.sv
module dma_cascade_engine
  import dma_pkg::*;
#(
  parameter int CPC = 4,
  parameter int AW  = 16,
  parameter int PW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CPC-1:0]       byte_drq,
  input  logic [CPC-1:1]       word_drq,
  input  logic                 hlda,
  input  logic                 cfg_we,
  input  logic [$clog2(2*CPC)-1:0] cfg_chan,
  input  logic [PW-1:0]        cfg_page,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [AW-1:0]        cfg_count,
  input  logic                 cfg_dec,
  input  logic                 cfg_autoinit,
  input  logic [1:0]           cfg_type,
  input  logic                 mask_we,
  input  logic [$clog2(2*CPC)-1:0] mask_chan,
  input  logic                 mask_val,
  output logic                 hrq,
  output logic [2*CPC-1:0]     dack,
  output logic                 tc,
  output logic                 mem_cyc,
  output logic [1:0]           xfer_dir,
  output logic [PW+AW-1:0]     phys_addr,
  output logic [2*CPC-1:0]     tc_stat
);

  localparam int NCH  = 2 * CPC;
  localparam int CW   = $clog2(NCH);
  localparam int IW   = (CPC > 1) ? $clog2(CPC) : 1;
  localparam int CASC = CPC;
  localparam int PAW  = PW + AW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // per-channel state
  logic [AW-1:0] ch_addr [NCH];
  logic [PW-1:0] ch_page [NCH];
  chan_mode_t    ch_mode [NCH];
  logic [NCH-1:0] ch_mask, ch_zero, ch_tcf, step;
  chan_mode_t    ld_mode;

  assign ld_mode = '{dec: cfg_dec, autoinit: cfg_autoinit, kind: xfer_e'(cfg_type)};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_state #(.AW(AW), .PW(PW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_i),
      .step     (step[c]),
      .load     (cfg_we && cfg_chan == CW'(c)),
      .ld_page  (cfg_page),
      .ld_addr  (cfg_addr),
      .ld_count (cfg_count),
      .ld_mode  (ld_mode),
      .mask_we  (mask_we && mask_chan == CW'(c)),
      .mask_val (mask_val),
      .cur_addr (ch_addr[c]),
      .page     (ch_page[c]),
      .mode     (ch_mode[c]),
      .masked   (ch_mask[c]),
      .at_zero  (ch_zero[c]),
      .tc_flag  (ch_tcf[c])
    );
  end

  // two-level fixed-priority arbitration
  logic [CPC-1:0] pend_byte, pend_word;
  logic           byte_any, word_any;
  logic [IW-1:0]  byte_idx, word_idx;

  assign pend_byte = byte_drq & ~ch_mask[CPC-1:0];
  assign pend_word = {word_drq, byte_any} & ~ch_mask[NCH-1:CPC];

  dma_prio_pick #(.N(CPC)) u_pick_byte (.req(pend_byte), .any(byte_any), .idx(byte_idx));
  dma_prio_pick #(.N(CPC)) u_pick_word (.req(pend_word), .any(word_any), .idx(word_idx));

  logic           svc, is_word, wrap_sel;
  logic [CW-1:0]  sel;
  logic [AW-1:0]  addr_sel;
  logic [PW-1:0]  page_sel;
  xfer_e          kind_sel;
  logic [PAW-1:0] phys;

  assign svc      = hlda && word_any;
  assign is_word  = (word_idx != '0);
  assign sel      = is_word ? CW'(CASC) + CW'(word_idx) : CW'(byte_idx);
  assign step     = svc ? (NCH'(1) << sel) : '0;
  assign addr_sel = ch_addr[sel];
  assign page_sel = ch_page[sel];
  assign kind_sel = ch_mode[sel].kind;
  assign wrap_sel = ch_zero[sel];
  assign phys     = {page_sel, {AW{1'b0}}}
                  | (is_word ? PAW'({addr_sel, 1'b0}) : PAW'(addr_sel));

  // registered outputs: next state
  logic           hrq_q, hrq_n, tc_q, tc_n, memc_q, memc_n;
  logic [NCH-1:0] dack_q, dack_n;
  logic [1:0]     dir_q, dir_n;
  logic [PAW-1:0] addr_q, addr_n;

  always_comb begin
    dack_n = step;
    if (svc && !is_word) dack_n[CASC] = 1'b1;
    tc_n   = svc && wrap_sel;
    memc_n = svc && (kind_sel == XF_TO_MEM || kind_sel == XF_TO_DEV);
    dir_n  = svc ? kind_sel : dir_q;
    addr_n = svc ? phys : addr_q;
    hrq_n  = word_any && !tc_n;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hrq_q  <= 1'b0;
      dack_q <= '0;
      tc_q   <= 1'b0;
      memc_q <= 1'b0;
      dir_q  <= 2'b00;
      addr_q <= '0;
    end else begin
      hrq_q  <= hrq_n;
      dack_q <= dack_n;
      tc_q   <= tc_n;
      memc_q <= memc_n;
      dir_q  <= dir_n;
      addr_q <= addr_n;
    end
  end

  assign hrq       = hrq_q;
  assign dack      = dack_q;
  assign tc        = tc_q;
  assign mem_cyc   = memc_q;
  assign xfer_dir  = dir_q;
  assign phys_addr = addr_q;
  assign tc_stat   = ch_tcf;

  // R2: a served byte channel is always accompanied by the cascade acknowledge
  assert_cascade_ack_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (|dack[CPC-1:0]) |-> (dack[CASC] && $countones(dack) == 2));

  // R4: at most one device channel plus the cascade bit
  assert_single_ack_R4: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(dack) <= 2);

  // R7: terminal count only with an acknowledge
  assert_tc_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_i)
    tc |-> (dack != '0));

  // R9: hold request is dropped while terminal count is shown
  assert_tc_drops_hrq_R9: assert property (@(posedge clk) disable iff (!rst_i)
    tc |-> !hrq);

  // R10: no acknowledge without a preceding hold acknowledge
  assert_idle_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !$past(hlda) |-> (dack == '0 && !tc));

  // R11: memory cycle only for the two moving types
  assert_memcyc_type_R11: assert property (@(posedge clk) disable iff (!rst_i)
    mem_cyc |-> (dack != '0 && (xfer_dir == 2'b01 || xfer_dir == 2'b10)));

endmodule

// File: tb/sim_dma_cascade_engine.sv
module sim_dma_cascade_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  byte_drq;
  logic [3:1]  word_drq;
  logic        hlda, cfg_we, cfg_dec, cfg_autoinit, mask_we, mask_val;
  logic [2:0]  cfg_chan, mask_chan;
  logic [7:0]  cfg_page;
  logic [15:0] cfg_addr, cfg_count;
  logic [1:0]  cfg_type;
  logic        hrq, tc, mem_cyc;
  logic [7:0]  dack, tc_stat;
  logic [1:0]  xfer_dir;
  logic [23:0] phys_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cascade_engine u0 (
    .clk(clk), .rst_n(rst_n), .byte_drq(byte_drq), .word_drq(word_drq), .hlda(hlda),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_page(cfg_page), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_dec(cfg_dec), .cfg_autoinit(cfg_autoinit),
    .cfg_type(cfg_type), .mask_we(mask_we), .mask_chan(mask_chan), .mask_val(mask_val),
    .hrq(hrq), .dack(dack), .tc(tc), .mem_cyc(mem_cyc), .xfer_dir(xfer_dir),
    .phys_addr(phys_addr), .tc_stat(tc_stat)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural reference model
  logic        m_mask [8];
  logic [15:0] m_ba [8], m_ca [8], m_bc [8], m_cc [8];
  logic [7:0]  m_pg [8];
  logic        m_dec [8], m_ai [8];
  logic [1:0]  m_ty [8];
  logic [7:0]  m_tcs, exp_dack;
  logic        exp_hrq, exp_tc, exp_mem;
  logic [1:0]  exp_dir;
  logic [23:0] exp_addr;

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] pend;
    logic bany, wany, ntc;
    int w, s;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_mask[i] = 1; m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
        m_pg[i] = 0; m_dec[i] = 0; m_ai[i] = 0; m_ty[i] = 0;
      end
      m_tcs = 0; exp_dack = 0; exp_hrq = 0; exp_tc = 0; exp_mem = 0;
      exp_dir = 0; exp_addr = 0;
    end else begin
      pend = 0;
      for (int i = 0; i < 4; i++) pend[i] = byte_drq[i] & ~m_mask[i];
      bany = |pend[3:0];
      pend[4] = bany & ~m_mask[4];
      for (int i = 5; i < 8; i++) pend[i] = word_drq[i-4] & ~m_mask[i];
      wany = |pend[7:4];
      exp_dack = 0; exp_mem = 0; ntc = 0;
      if (hlda && wany) begin
        w = -1;
        for (int i = 4; i < 8; i++) if (pend[i] && w < 0) w = i;
        s = w;
        if (w == 4) begin
          s = -1;
          for (int i = 0; i < 4; i++) if (pend[i] && s < 0) s = i;
          exp_dack[4] = 1;
        end
        exp_dack[s] = 1;
        exp_addr = {m_pg[s], 16'h0} | ((s >= 4) ? ({8'h0, m_ca[s]} << 1) : {8'h0, m_ca[s]});
        exp_dir = m_ty[s];
        exp_mem = (m_ty[s] == 2'b01) || (m_ty[s] == 2'b10);
        m_ca[s] = m_dec[s] ? m_ca[s] - 1 : m_ca[s] + 1;
        if (m_cc[s] == 0) begin
          ntc = 1; m_tcs[s] = 1; m_cc[s] = 16'hffff;
          if (m_ai[s]) begin m_ca[s] = m_ba[s]; m_cc[s] = m_bc[s]; end
          else m_mask[s] = 1;
        end else m_cc[s] = m_cc[s] - 1;
      end
      exp_tc  = ntc;
      exp_hrq = wany && !ntc;
      if (cfg_we) begin
        m_ba[cfg_chan] = cfg_addr; m_ca[cfg_chan] = cfg_addr;
        m_bc[cfg_chan] = cfg_count; m_cc[cfg_chan] = cfg_count;
        m_pg[cfg_chan] = cfg_page; m_dec[cfg_chan] = cfg_dec;
        m_ai[cfg_chan] = cfg_autoinit; m_ty[cfg_chan] = cfg_type;
        m_tcs[cfg_chan] = 0;
      end
      if (mask_we) m_mask[mask_chan] = mask_val;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 hrq", 32'(hrq), 32'(exp_hrq));
      chk("R4 dack", 32'(dack), 32'(exp_dack));
      chk("R7 tc", 32'(tc), 32'(exp_tc));
      chk("R11 mem_cyc", 32'(mem_cyc), 32'(exp_mem));
      chk("R11 xfer_dir", 32'(xfer_dir), 32'(exp_dir));
      chk("R5 phys_addr", 32'(phys_addr), 32'(exp_addr));
      chk("R7 tc_stat", 32'(tc_stat), 32'(m_tcs));
    end
  end

  task automatic cfg_ch(input int ch, input logic [7:0] pg, input logic [15:0] ad,
                        input logic [15:0] cn, input logic dc, input logic ai, input logic [1:0] ty);
    @(negedge clk);
    cfg_chan = 3'(ch); cfg_page = pg; cfg_addr = ad; cfg_count = cn;
    cfg_dec = dc; cfg_autoinit = ai; cfg_type = ty; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_mask(input int ch, input logic v);
    @(negedge clk);
    mask_chan = 3'(ch); mask_val = v; mask_we = 1;
    @(negedge clk);
    mask_we = 0;
  endtask

  task automatic pulse_hlda();
    @(negedge clk);
    hlda = 1;
    @(negedge clk);
    hlda = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; byte_drq = 0; word_drq = 0; hlda = 0; cfg_we = 0; cfg_chan = 0;
    cfg_page = 0; cfg_addr = 0; cfg_count = 0; cfg_dec = 0; cfg_autoinit = 0;
    cfg_type = 0; mask_we = 0; mask_chan = 0; mask_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    cmp_on = 1;
    chk("R12 reset hrq", 32'(hrq), 0);
    chk("R12 reset dack", 32'(dack), 0);
    chk("R12 reset tc_stat", 32'(tc_stat), 0);

    // masked after reset: a request raises nothing
    word_drq = 3'b001;
    repeat (2) @(negedge clk);
    chk("R12 reset masks block hrq", 32'(hrq), 0);
    word_drq = 0;

    cfg_ch(0, 8'h01, 16'h0100, 16'd1,  0, 1, 2'b01);
    cfg_ch(1, 8'h34, 16'h5678, 16'h10, 1, 0, 2'b10);
    cfg_ch(2, 8'h02, 16'h2000, 16'd0,  0, 0, 2'b00);
    cfg_ch(3, 8'h03, 16'h3000, 16'd5,  0, 0, 2'b01);
    cfg_ch(5, 8'h12, 16'h8001, 16'h20, 0, 0, 2'b01);
    cfg_ch(6, 8'h06, 16'h0600, 16'd4,  0, 0, 2'b11);
    cfg_ch(7, 8'h07, 16'h0700, 16'd4,  0, 0, 2'b10);
    for (int c = 0; c < 8; c++) set_mask(c, 0);

    // R10: acknowledge with nothing pending
    @(negedge clk); hlda = 1;
    repeat (3) @(negedge clk);
    chk("R10 idle dack", 32'(dack), 0);
    chk("R10 idle tc", 32'(tc), 0);
    hlda = 0;

    // R1/R3/R5: word priority and address shift
    word_drq = 3'b111;
    @(negedge clk);
    chk("R3 hrq raised", 32'(hrq), 1);
    pulse_hlda();
    chk("R1 lowest word channel", 32'(dack), 32'h20);
    chk("R5 word address shifted", 32'(phys_addr), 32'h130002);
    chk("R11 to-mem cycle", 32'(mem_cyc), 1);

    // R1: lowering a line re-arbitrates; R11: undefined type
    word_drq = 3'b110;
    pulse_hlda();
    chk("R1 rearbitrate after drop", 32'(dack), 32'h40);
    chk("R11 undefined type no cycle", 32'(mem_cyc), 0);
    chk("R11 undefined dir", 32'(xfer_dir), 3);

    // R2: cascade forwarding beats word channels
    byte_drq = 4'b0110;
    pulse_hlda();
    chk("R2 byte channel via cascade", 32'(dack), 32'h12);
    chk("R5 byte address", 32'(phys_addr), 32'h345678);
    pulse_hlda();
    chk("R6 decrement address", 32'(phys_addr), 32'h345677);

    // R2: masked cascade slot hides byte requests
    word_drq = 0;
    set_mask(4, 1);
    byte_drq = 4'b0010;
    repeat (2) @(negedge clk);
    chk("R2 cascade mask blocks hrq", 32'(hrq), 0);
    set_mask(4, 0);

    // R7/R9: terminal count without autoinit
    byte_drq = 4'b0100;
    @(negedge clk);
    pulse_hlda();
    chk("R7 tc pulse", 32'(tc), 1);
    chk("R7 tc ack", 32'(dack), 32'h14);
    chk("R9 hrq low on tc", 32'(hrq), 0);
    chk("R11 verify no cycle", 32'(mem_cyc), 0);
    chk("R7 tc_stat set", 32'(tc_stat), 32'h04);
    @(negedge clk);
    chk("R7 masked after tc", 32'(hrq), 0);
    pulse_hlda();
    chk("R7 no further service", 32'(dack), 0);

    // R8: autoinit reload
    byte_drq = 4'b0001;
    pulse_hlda();
    chk("R8 first step addr", 32'(phys_addr), 32'h010100);
    pulse_hlda();
    chk("R6 increment addr", 32'(phys_addr), 32'h010101);
    chk("R8 tc on wrap", 32'(tc), 1);
    pulse_hlda();
    chk("R8 reloaded addr", 32'(phys_addr), 32'h010100);
    chk("R8 stays unmasked", 32'(dack), 32'h11);

    // R12: load clears sticky flag
    byte_drq = 0;
    cfg_ch(2, 8'h02, 16'h2000, 16'd2, 0, 0, 2'b00);
    chk("R12 load clears tc_stat", 32'(tc_stat), 32'h01);

    // mixed phase, compared against the model every clock
    cfg_ch(3, 8'h33, 16'hfffe, 16'd3, 0, 1, 2'b10);
    cfg_ch(6, 8'h66, 16'h0001, 16'd2, 1, 0, 2'b01);
    cfg_ch(7, 8'h77, 16'hffff, 16'd1, 0, 1, 2'b00);
    lfsr = 16'hace1;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      byte_drq = lfsr[3:0];
      word_drq = lfsr[6:4];
      hlda = lfsr[8] | lfsr[2];
      mask_we = (k % 7 == 0);
      mask_chan = lfsr[11:9];
      mask_val = lfsr[12] & lfsr[13];
    end
    @(negedge clk);
    hlda = 0; mask_we = 0; byte_drq = 0; word_drq = 0;
    repeat (3) @(negedge clk);
    chk("R3 hrq low when idle", 32'(hrq), 0);
    finish_run();
  end

endmodule